// File: doc/BRIEF.md
# Octal DAC Serial Command Decoder

This block is the digital front end of an eight-channel DAC that is programmed over a serial link. A host sends a serial data pin, a shift clock and a frame select line. The block samples all three pins in its own system clock domain and finds their edges there. While select is low, each rising shift clock moves one bit into a 16-bit shift register. The register's far end drives a serial output, so several of these blocks can be chained on one link.

When select rises, the captured word is decoded and carried out. The upper byte is a channel bitmask and the lower byte is the payload. A non-zero mask writes the payload into every channel whose mask bit is set. A zero mask with the payload's top bit set loads a 6-bit buffer-mode register. A zero mask with that top bit clear does nothing, and a chain uses it to skip a device. The mode register is decoded into a buffer-enable flag and a full/half-buffer flag for each channel.

Top module: `octdac_front`

## Requirements
- R1: After reset, all eight channel codes, the mode register, every buffer-enable flag and every full-buffer flag are zero.
- R2: While select is low, each rising shift clock moves the sampled data pin into bit 0 of a 16-bit word and moves every other bit up one place. The first bit sent of a 16-bit frame ends in bit 15 (mask bit 7), and the last bit sent ends in bit 0 (payload bit 0).
- R3: The serial output always shows word bit 15. It therefore repeats the input stream 16 shift clocks later, in the same order.
- R4: A rising edge of select carries out the captured word. Shift clock edges while select is high do not change the word or the serial output. A falling edge of select changes no register.
- R5: If word[15:8] is zero and word[7] is 0, no channel code and no mode bit changes, whatever word[6:0] holds.
- R6: If word[15:8] is non-zero, every channel i with word[8+i] set takes word[7:0] as its code. All other channels and the mode register keep their values.
- R7: If word[15:8] is zero and word[7] is 1, the mode register takes word[5:0], with mode bit k equal to word bit k. Word bit 6 is ignored, and no channel code changes.
- R8: Buffer enables are set in pairs. Mode bit 1 sets channels 6 and 7, mode bit 2 sets channels 4 and 5, mode bit 4 sets channels 2 and 3, and mode bit 5 sets channels 0 and 1. A 1 means buffered.
- R9: Mode bit 0 sets the full-buffer flag of channels 4 to 7, and mode bit 3 sets the flag of channels 0 to 3. A 0 means half-buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sclk_i | input | 1 | Serial shift clock, sampled by clk |
| sel_i | input | 1 | Frame select: low to shift, rising edge to carry out the word |
| din_i | input | 1 | Serial data in, most significant bit first |
| dout_o | output | 1 | Serial data out for chaining, equal to word bit 15 |
| code_o | output | 64 | Channel codes; channel i is at bits [8i+7:8i] |
| mode_o | output | 6 | Buffer-mode register |
| buf_en_o | output | 8 | Per-channel buffer enable |
| full_o | output | 8 | Per-channel full-buffer flag (0 = half) |

## Verification
Each pin passes through two register stages before anything acts on it. A shift, or the carrying out of a word, therefore shows at the outputs after the second rising clk edge following the pin change. The mode flags follow the mode register combinationally, in the same cycle. The bench changes pins only on falling clk edges and holds each level for three clk cycles. It reads outputs only on a falling edge after that hold, so every result is already settled when read. The serial output is checked before each new shift clock. At that point it must still show the bit from sixteen shifts earlier.

// File: rtl/octdac_pkg.sv
package octdac_pkg;
  localparam int NCH    = 8;
  localparam int CODE_W = 8;
  localparam int WORD_W = NCH + CODE_W;
  localparam int MODE_W = 6;
  localparam int OUT_W  = NCH * CODE_W;

  typedef enum logic [1:0] {CMD_NOP, CMD_SET, CMD_MODE} cmd_e;

  function automatic cmd_e classify(input logic [WORD_W-1:0] w);
    if (|w[WORD_W-1:CODE_W])  return CMD_SET;
    else if (w[CODE_W-1])     return CMD_MODE;
    else                      return CMD_NOP;
  endfunction
endpackage

// File: rtl/octdac_rst_sync.sv
module octdac_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage <= 2'b00;
    else         stage <= {stage[0], 1'b1};
  end

  assign rst_n_o = stage[1];
endmodule

// File: rtl/octdac_pin_sync.sv
module octdac_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o
);
  logic cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cur_q  <= pin_i;
      prev_q <= cur_q;
    end
  end

  assign lvl_o  = cur_q;
  assign rise_o = cur_q & ~prev_q;
endmodule

// File: rtl/octdac_shreg.sv
module octdac_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] word_o,
  output logic         dout_o
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (en) sr_d = {sr_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign word_o = sr_q;
  assign dout_o = sr_q[W-1];
endmodule

// File: rtl/octdac_regs.sv
module octdac_regs
  import octdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  output logic [OUT_W-1:0]  code_o,
  output logic [MODE_W-1:0] mode_o
);
  logic [CODE_W-1:0] code_q [NCH];
  logic [MODE_W-1:0] mode_q, mode_d;
  cmd_e              cmd;
  logic [NCH-1:0]    ch_we;

  assign cmd = classify(word);

  always_comb begin
    mode_d = mode_q;
    ch_we  = '0;
    if (commit) begin
      unique case (cmd)
        CMD_SET:  ch_we  = word[WORD_W-1:CODE_W];
        CMD_MODE: mode_d = word[MODE_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        code_q[i] <= '0;
      else if (ch_we[i]) code_q[i] <= word[CODE_W-1:0];
    end
    assign code_o[i*CODE_W +: CODE_W] = code_q[i];
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/octdac_front.sv
module octdac_front
  import octdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sel_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic [OUT_W-1:0]  code_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [NCH-1:0]    buf_en_o,
  output logic [NCH-1:0]    full_o
);
  logic              rst_s_n;
  logic              sclk_lvl, sclk_rise;
  logic              sel_lvl, sel_rise;
  logic              din_lvl, din_rise;
  logic              shift_en, commit;
  logic [WORD_W-1:0] word;

  octdac_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_s_n));

  octdac_pin_sync u_sclk (.clk(clk), .rst_n(rst_s_n), .pin_i(sclk_i),
                          .lvl_o(sclk_lvl), .rise_o(sclk_rise));
  octdac_pin_sync u_sel  (.clk(clk), .rst_n(rst_s_n), .pin_i(sel_i),
                          .lvl_o(sel_lvl), .rise_o(sel_rise));
  octdac_pin_sync u_din  (.clk(clk), .rst_n(rst_s_n), .pin_i(din_i),
                          .lvl_o(din_lvl), .rise_o(din_rise));

  assign shift_en = sclk_rise & ~sel_lvl;
  assign commit   = sel_rise;

  octdac_shreg #(.W(WORD_W)) u_sr (
    .clk(clk), .rst_n(rst_s_n), .en(shift_en), .din(din_lvl),
    .word_o(word), .dout_o(dout_o)
  );

  octdac_regs u_regs (
    .clk(clk), .rst_n(rst_s_n), .commit(commit), .word(word),
    .code_o(code_o), .mode_o(mode_o)
  );

  // Pair enables: mode bits 5,4,2,1 drive channel pairs 0-1, 2-3, 4-5, 6-7.
  localparam int PAIR_BIT [4] = '{5, 4, 2, 1};
  for (genvar p = 0; p < NCH/2; p++) begin : g_pair
    assign buf_en_o[2*p]   = mode_o[PAIR_BIT[p]];
    assign buf_en_o[2*p+1] = mode_o[PAIR_BIT[p]];
  end

  // Full-buffer groups: mode bit 3 for low half, mode bit 0 for high half.
  assign full_o = {{(NCH/2){mode_o[0]}}, {(NCH/2){mode_o[3]}}};

  logic unused_din_rise;
  assign unused_din_rise = din_rise;
endmodule

// File: rtl/octdac_chk.sv
module octdac_chk
  import octdac_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              commit,
  input logic              sel_lvl,
  input logic [WORD_W-1:0] word,
  input logic [OUT_W-1:0]  code_o,
  input logic [MODE_W-1:0] mode_o,
  input logic [NCH-1:0]    buf_en_o,
  input logic [NCH-1:0]    full_o
);
  wire addr_zero = (word[WORD_W-1:CODE_W] == '0);

  assert_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit && addr_zero && !word[CODE_W-1] |=> $stable(code_o) && $stable(mode_o));

  assert_set_keeps_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !addr_zero |=> $stable(mode_o));

  assert_mode_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit && addr_zero && word[CODE_W-1] |=> mode_o == $past(word[MODE_W-1:0]));

  assert_mode_keeps_codes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit && addr_zero && word[CODE_W-1] |=> $stable(code_o));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(code_o) && $stable(mode_o));

  assert_no_shift_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_lvl |=> $stable(word));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assert_set_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      commit && word[CODE_W+i] |=> code_o[i*CODE_W +: CODE_W] == $past(word[CODE_W-1:0]));
  end

  for (genvar p = 0; p < NCH/2; p++) begin : g_pair
    assert_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
      buf_en_o[2*p] == buf_en_o[2*p+1]);
  end

  assert_full_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(full_o[NCH/2-1:0]) % (NCH/2) == 0) &&
    ($countones(full_o[NCH-1:NCH/2]) % (NCH/2) == 0));
endmodule

bind octdac_front octdac_chk u_chk (
  .clk(clk), .rst_n(rst_s_n), .commit(commit), .sel_lvl(sel_lvl), .word(word),
  .code_o(code_o), .mode_o(mode_o), .buf_en_o(buf_en_o), .full_o(full_o)
);

// File: tb/tb_octdac_front.sv
module tb_octdac_front;
  localparam int HOLD = 3;

  logic        clk = 1'b0;
  logic        rst_n, sclk_i, sel_i, din_i;
  logic        dout_o;
  logic [63:0] code_o;
  logic [5:0]  mode_o;
  logic [7:0]  buf_en_o, full_o;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_code [8];
  logic [5:0] m_mode;

  always #10 clk = ~clk;

  octdac_front dut (.*);

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
    $finish;
  end

  task automatic hold();
    repeat (HOLD) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_buf();
    logic [7:0] b;
    b[1:0] = {2{m_mode[5]}};
    b[3:2] = {2{m_mode[4]}};
    b[5:4] = {2{m_mode[2]}};
    b[7:6] = {2{m_mode[1]}};
    return b;
  endfunction

  function automatic logic [7:0] exp_full();
    return {{4{m_mode[0]}}, {4{m_mode[3]}}};
  endfunction

  task automatic check_all(input string req);
    logic [63:0] c;
    for (int i = 0; i < 8; i++) c[i*8 +: 8] = m_code[i];
    check({req, " codes"}, code_o, c);
    check({req, " mode"}, {58'd0, mode_o}, {58'd0, m_mode});
    check({req, " buf_en"}, {56'd0, buf_en_o}, {56'd0, exp_buf()});
    check({req, " full"}, {56'd0, full_o}, {56'd0, exp_full()});
  endtask

  task automatic model(input logic [15:0] w);
    if (w[15:8] != 0) begin
      for (int i = 0; i < 8; i++) if (w[8+i]) m_code[i] = w[7:0];
    end else if (w[7]) m_mode = w[5:0];
  endtask

  task automatic shift_bit(input logic b);
    din_i = b; sclk_i = 1'b0; hold();
    sclk_i = 1'b1; hold();
  endtask

  task automatic send_word(input logic [15:0] w);
    sel_i = 1'b0; hold();
    for (int j = 15; j >= 0; j--) shift_bit(w[j]);
    sclk_i = 1'b0; hold();
    sel_i = 1'b1; hold();
    model(w);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sclk_i = 1'b0; sel_i = 1'b1; din_i = 1'b0;
    for (int i = 0; i < 8; i++) m_code[i] = 8'h00;
    m_mode = 6'd0;
    hold();
    rst_n = 1'b1; hold();
    check_all("R1 reset");
  endtask

  task automatic t_set();
    send_word(16'h81A5); check_all("R6 set mask 81");
    send_word(16'hFF3C); check_all("R6 set all");
    send_word(16'h1207); check_all("R6 set mask 12 (R2 order)");
    send_word(16'h0169); check_all("R2 ch0 payload order");
  endtask

  task automatic t_mode();
    send_word(16'h00FF); check_all("R7 mode D6 ignored");
    send_word(16'h0081); check_all("R9 high group full");
    send_word(16'h0088); check_all("R9 low group full");
    send_word(16'h0086); check_all("R8 pairs 4-7");
    send_word(16'h00B0); check_all("R8 pairs 0-3");
    send_word(16'h00C0); check_all("R7 D6 only clears mode");
  endtask

  task automatic t_nop();
    send_word(16'h2277); check_all("R6 before nop");
    send_word(16'h007F); check_all("R5 nop all low bits set");
    send_word(16'h0000); check_all("R5 nop zero");
  endtask

  task automatic t_chain();
    logic [15:0] w1, w2;
    w1 = 16'hC3A6; w2 = 16'h4055;
    send_word(w1);
    check("R3 dout after frame", {63'd0, dout_o}, {63'd0, w1[15]});
    sel_i = 1'b0; hold();
    for (int j = 15; j >= 0; j--) begin
      check("R3 dout delayed stream", {63'd0, dout_o}, {63'd0, w1[j]});
      shift_bit(w2[j]);
    end
    sclk_i = 1'b0; hold();
    check("R3 dout shows new frame", {63'd0, dout_o}, {63'd0, w2[15]});
    sel_i = 1'b1; hold();
    model(w2);
    check_all("R3 chained word committed");
    for (int k = 0; k < 5; k++) shift_bit(~w2[14]);
    sclk_i = 1'b0; hold();
    check("R4 no shift while high", {63'd0, dout_o}, {63'd0, w2[15]});
    sel_i = 1'b0; hold();
    check_all("R4 falling select no change");
    sel_i = 1'b1; hold();
    model(w2);
    check_all("R4 recommit unchanged word");
  endtask

  initial begin
    t_reset();
    t_set();
    t_mode();
    t_nop();
    t_chain();
    report();
    $finish;
  end
endmodule